// File: doc/BRIEF.md
# Pulse-Swallow Main Frequency Divider

This block is the main feedback divider of a frequency synthesizer. It divides an RF-side input clock by N = P*B + A and emits one single-cycle pulse per N input cycles, which goes to the phase detector. The structure has three parts. A digital model of a dual-modulus prescaler divides by P or by P+1. A swallow counter decides how many prescaler cycles use the larger modulus. A main counter sets how many prescaler cycles make up one output period.

A 2-bit code selects the base modulus P. The swallow value A and the main value B arrive on parallel inputs. A combinational flag reports a setting that cannot be divided correctly, and such a setting is never taken. A new setting takes effect only at the boundary between output periods. A counter-hold input freezes the divider at the start of a period. The same control is meant to hold the reference divider, so both resume together in phase.

Top module: `swallow_divider`

## Requirements
- R1: The distance between consecutive output pulses is exactly P*B + A input cycles, for the active setting.
- R2: The modulus code maps as follows: code 0 gives P=8 (8/9), code 1 gives P=16, code 2 gives P=32 and code 3 gives P=64.
- R3: Swallow values from 0 to 63 are supported, including A equal to B (for example A=B=63 with P=8 gives N=567).
- R4: Main values from 3 up to 8191 are supported (B=3 with A=3 and P=64 gives 195; B=8191 with A=0 and P=8 gives 65528).
- R5: `cfg_bad` is 1 exactly when the input setting has A greater than B or B below 3. It is combinational on the inputs.
- R6: A setting with `cfg_bad` high is never taken. The output period stays at the previously active N.
- R7: Input changes made during a period take effect only from the next period. The period in progress completes with the old N.
- R8: While `cnt_hold` is 1, no pulse is produced. After release, the first pulse appears exactly N rising edges after the first edge that sees `cnt_hold` low.
- R9: Synchronous reset clears the pulse output and takes the input setting if it is valid, or otherwise P=8, A=0, B=3. After release, the first pulse follows the same timing as in R8.
- R10: Each output pulse lasts exactly one input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF-side input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cnt_hold | input | 1 | Counter hold: keeps the divider at period start while high |
| psel | input | 2 | Prescaler modulus code |
| a_val | input | AW (6) | Swallow count A |
| b_val | input | BW (13) | Main count B |
| div_out | output | 1 | Divided output, one pulse per N input cycles |
| cfg_bad | output | 1 | Input setting is illegal (A > B or B < 3) |

## Verification
The bench looks for off-by-one errors in the swallow window. A design that compares the main counter with A using the wrong relation gives periods of N±1, or N±P when A equals B. Each modulus code is checked with one fixed setting, so a wrong code mapping shows up as a period scaled by a factor of two. A setting changed just after a pulse must not shorten or stretch the period already under way. A design that loads its inputs at once would show the new N one period early. Illegal settings and the full 13-bit main count are driven on purpose. A design that takes a bad setting produces a wrong period, and a truncated counter wraps far short of 65528 cycles.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int AW = 6,
  parameter int BW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_hold,
  input  logic [1:0]    psel,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  output logic          div_out,
  output logic          cfg_bad
);
  localparam int PCW = 7;
  localparam logic [BW-1:0] B_MIN = BW'(3);

  logic [1:0]     cur_p;
  logic [AW-1:0]  cur_a;
  logic [BW-1:0]  cur_b;
  logic [PCW-1:0] pc;
  logic [BW-1:0]  bc;

  wire            swallow = {{(BW-AW){1'b0}}, cur_a} > bc;
  wire [PCW-1:0]  mod_m1  = (PCW'(8) << cur_p) - PCW'(1) + PCW'(swallow);
  wire            pre_end = pc == mod_m1;
  wire            per_end = pre_end && (bc == cur_b - BW'(1));

  assign cfg_bad = ({{(BW-AW){1'b0}}, a_val} > b_val) || (b_val < B_MIN);

  always_ff @(posedge clk) begin
    if (rst && cfg_bad) begin
      cur_p <= 2'd0;
      cur_a <= '0;
      cur_b <= B_MIN;
    end else if ((rst || cnt_hold || per_end) && !cfg_bad) begin
      cur_p <= psel;
      cur_a <= a_val;
      cur_b <= b_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_hold) begin
      pc      <= '0;
      bc      <= '0;
      div_out <= 1'b0;
    end else if (pre_end) begin
      pc      <= '0;
      bc      <= per_end ? '0 : bc + BW'(1);
      div_out <= per_end;
    end else begin
      pc      <= pc + PCW'(1);
      div_out <= 1'b0;
    end
  end
endmodule

module swallow_divider_chk #(
  parameter int AW = 6,
  parameter int BW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_hold,
  input logic          div_out,
  input logic          cfg_bad,
  input logic          per_end,
  input logic [1:0]    cur_p,
  input logic [AW-1:0] cur_a,
  input logic [BW-1:0] cur_b,
  input logic [BW-1:0] bc
);
  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_hold |=> !div_out);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !div_out);

  // R6
  bad_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> ($stable(cur_p) && $stable(cur_a) && $stable(cur_b)));

  // R7
  mid_period_chk: assert property (@(posedge clk) disable iff (rst)
    (!per_end && !cnt_hold) |=> ($stable(cur_p) && $stable(cur_a) && $stable(cur_b)));

  // R1
  main_range_chk: assert property (@(posedge clk) disable iff (rst)
    bc < cur_b);
endmodule

bind swallow_divider swallow_divider_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .cnt_hold(cnt_hold), .div_out(div_out),
  .cfg_bad(cfg_bad), .per_end(per_end), .cur_p(cur_p), .cur_a(cur_a),
  .cur_b(cur_b), .bc(bc)
);

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_hold = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [5:0]  a_val = 6'd0;
  logic [12:0] b_val = 13'd5;
  logic        div_out;
  logic        cfg_bad;

  int checks = 0;
  int errors = 0;
  int prev_n = 0;
  bit done = 1'b0;

  swallow_divider u0 (
    .clk(clk), .rst(rst), .cnt_hold(cnt_hold), .psel(psel),
    .a_val(a_val), .b_val(b_val), .div_out(div_out), .cfg_bad(cfg_bad)
  );

  always #10 clk = ~clk;

  function automatic int exp_n(input int code, input int a, input int b);
    return (8 << code) * b + a;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_out);
  endtask

  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!div_out);
  endtask

  task automatic apply_and_check(input int code, input int a, input int b, input string tag);
    int n;
    int e;
    wait_pulse();
    psel = 2'(code); a_val = 6'(a); b_val = 13'(b);
    #1;
    check(cfg_bad == 1'b0, {tag, " R5 flag low"}, int'(cfg_bad), 0);
    count_to_pulse(n);
    check(n == prev_n, {tag, " R7 old period kept"}, n, prev_n);
    e = exp_n(code, a, b);
    count_to_pulse(n);
    check(n == e, {tag, " R1 period"}, n, e);
    prev_n = e;
  endtask

  task automatic try_bad(input int a, input int b);
    int n;
    wait_pulse();
    a_val = 6'(a); b_val = 13'(b);
    #1;
    check(cfg_bad == 1'b1, "R5 flag high", int'(cfg_bad), 1);
    count_to_pulse(n);
    check(n == prev_n, "R6 period unchanged", n, prev_n);
    count_to_pulse(n);
    check(n == prev_n, "R6 period unchanged later", n, prev_n);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(div_out == 1'b0, "R9 output low in reset", int'(div_out), 0);
    check(cfg_bad == 1'b0, "R5 flag low at reset", int'(cfg_bad), 0);
    rst = 1'b0;
    count_to_pulse(n);
    check(n == 40, "R9 first period after reset", n, 40);
    @(negedge clk);
    check(div_out == 1'b0, "R10 pulse one cycle", int'(div_out), 0);
    prev_n = 40;

    for (int c = 0; c < 4; c++) apply_and_check(c, 5, 10, "R2 code");
    apply_and_check(0, 63, 63, "R3 A=B=63");
    apply_and_check(3, 3, 3, "R4 B min");
    apply_and_check(1, 0, 7, "R3 A zero");

    for (int i = 0; i < 12; i++) begin
      int b;
      int amax;
      int a;
      int code;
      code = int'($urandom % 4);
      b = 3 + int'($urandom % 38);
      amax = (b < 63) ? b : 63;
      a = int'($urandom % (amax + 1));
      apply_and_check(code, a, b, "R1 random");
    end

    try_bad(20, 10);
    try_bad(0, 2);
    apply_and_check(2, 4, 9, "R6 restore");

    @(negedge clk);
    cnt_hold = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (div_out) check(1'b0, "R8 pulse during hold", 1, 0);
    end
    check(div_out == 1'b0, "R8 quiet in hold", int'(div_out), 0);
    cnt_hold = 1'b0;
    count_to_pulse(n);
    check(n == prev_n, "R8 first period after hold", n, prev_n);

    apply_and_check(0, 0, 8191, "R4 B max");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule